// File: doc/BRIEF.md
# Address-Binding Packet Tag Inserter and Verifier

This block guards the routing header of on-chip network packets against an adversary that rewrites source or destination addresses in flight. A sending half takes a 6-bit source, a 6-bit destination and a 96-bit payload. It draws a fresh 8-bit label for every packet and derives a 20-bit key from that label. It then forms a 12-bit tag by XOR-ing the two addresses with the upper 12 key bits, and hides the tag inside the payload. The resulting 108-bit field is scrambled under the lower 8 key bits, and the label is mixed into the field as well. The output is a single 128-bit packet.

A receiving half runs the same steps in reverse. It recovers the label, rebuilds the key, undoes the scrambling and pulls out the hidden tag. It then compares that tag with one recomputed from the addresses it received. A match delivers source, destination and payload. A mismatch drops the packet and raises a one-cycle alarm. Both halves share one key derivation, a reduced lookup of sixteen 4-bit words with word shuffling, and one scrambler, which rotates small blocks in place. The secret bit placements of the tag and the label are compile-time parameters, and the same values must be given to both halves.

Top module: `pkt_tag_guard`

## Requirements
- R1: After a synchronous reset, `pkt_valid_o`, `rx_out_valid_o` and `hijack_o` are low, and both `tx_ready_o` and `rx_ready_o` are high.
- R2: In every emitted packet, bits [127:122] carry the accepted source and bits [121:116] carry the accepted destination, unchanged. The packet appears one cycle after acceptance.
- R3: The label of each packet is the low 8 bits of a 16-bit Fibonacci LFSR. The LFSR's next state is `{s[14:0], s[15]^s[13]^s[12]^s[10]}`, and its reset value is `SEED` (default 16'hACE1). It advances only on an accepted packet. Label bit i sits at body bit `(i*LBL_STRIDE+LBL_OFS) mod 116` (defaults 14 and 5), where the body is packet bits [115:0].
- R4: Key and field construction work as follows. Word w is `LUT[4w+3:4w]`. Sub-table s (0..4) yields word `2s+label[s]`. The first four selected words are permuted as `y[i]=x[i XOR label[6:5]]`, and `A={y3,y2,y1,y0}`. The key is `{x4,A}` when label[7]=1 and `{A,x4}` otherwise. Kt is key[19:8] and Ks is key[7:0]. The tag is `{src,dst} XOR Kt`. Tag bit j sits at field bit `(j*TAG_STRIDE+TAG_OFS) mod 108` (defaults 9 and 2), and payload bits fill the remaining field positions in ascending order.
- R5: The field is scrambled block by block, with 8-bit blocks and a final 4-bit block. Block b belongs to group g=b/2. It is rotated left by `{Ks[(g+2)%8],Ks[(g+1)%8],Ks[g%8]}` modulo its width. The label bits are then placed, and the scrambled field fills the other body positions in ascending order.
- R6: An unaltered packet accepted by the receiver is delivered one cycle later with the original source, destination and payload, and `hijack_o` stays low.
- R7: A received packet whose source or destination differs in any single bit from the one tagged raises `hijack_o` for exactly one cycle, one cycle after acceptance, and produces no `rx_out_valid_o`.
- R8: While `pkt_valid_o` is high and `pkt_ready_i` is low, the packet is held stable, `tx_ready_o` is low and no new packet is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid_i | input | 1 | Sender input valid |
| tx_ready_o | output | 1 | Sender can accept |
| tx_src_i | input | 6 | Source address to protect |
| tx_dst_i | input | 6 | Destination address to protect |
| tx_data_i | input | 96 | Payload |
| pkt_valid_o | output | 1 | Tagged packet valid |
| pkt_ready_i | input | 1 | Downstream takes packet |
| pkt_o | output | 128 | Tagged packet |
| rx_valid_i | input | 1 | Received packet valid |
| rx_ready_o | output | 1 | Receiver can accept |
| rx_pkt_i | input | 128 | Received packet |
| rx_out_valid_o | output | 1 | Authenticated payload valid |
| rx_out_ready_i | input | 1 | Consumer takes payload |
| rx_out_src_o | output | 6 | Delivered source |
| rx_out_dst_o | output | 6 | Delivered destination |
| rx_out_data_o | output | 96 | Delivered payload |
| hijack_o | output | 1 | One-cycle tamper alarm |

## Verification
A stuck or skipped LFSR step shows up in the very next packet. The label extracted from the body no longer matches the expected sequence, and the bench checks this for hundreds of consecutive packets. A wrong word choice, a wrong shuffle or a wrong block rotation changes the emitted 128-bit packet at once, so every packet is compared bit for bit with an independent model. The same faults inside the receiver turn a clean loop-back packet into a false alarm or a corrupted payload within one cycle. Every single-bit change in the address field is injected to confirm that the alarm fires and that delivery is withheld.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 96;
  localparam int TAG_W   = 2 * ADDR_W;
  localparam int LBL_W   = 8;
  localparam int FIELD_W = DATA_W + TAG_W;
  localparam int BODY_W  = FIELD_W + LBL_W;
  localparam int PKT_W   = BODY_W + TAG_W;
  localparam int KS_W    = 8;
  localparam int KEY_W   = TAG_W + KS_W;
  localparam int WORD_W  = 4;

  // index of the hidden bit mapped to position p, or -1
  function automatic int slot(input int p, input int cnt, input int stride,
                              input int ofs, input int wid);
    int r;
    r = -1;
    for (int j = 0; j < cnt; j++)
      if ((j * stride + ofs) % wid == p) r = j;
    return r;
  endfunction

  function automatic logic [FIELD_W-1:0] tag_put(input logic [DATA_W-1:0] d,
      input logic [TAG_W-1:0] t, input int stride, input int ofs);
    logic [FIELD_W-1:0] f;
    int k, s;
    f = '0; k = 0;
    for (int p = 0; p < FIELD_W; p++) begin
      s = slot(p, TAG_W, stride, ofs, FIELD_W);
      if (s >= 0) f[p] = t[s];
      else begin f[p] = d[k]; k++; end
    end
    return f;
  endfunction

  function automatic logic [TAG_W-1:0] tag_get(input logic [FIELD_W-1:0] f,
      input int stride, input int ofs);
    logic [TAG_W-1:0] t;
    int s;
    t = '0;
    for (int p = 0; p < FIELD_W; p++) begin
      s = slot(p, TAG_W, stride, ofs, FIELD_W);
      if (s >= 0) t[s] = f[p];
    end
    return t;
  endfunction

  function automatic logic [DATA_W-1:0] data_get(input logic [FIELD_W-1:0] f,
      input int stride, input int ofs);
    logic [DATA_W-1:0] d;
    int k;
    d = '0; k = 0;
    for (int p = 0; p < FIELD_W; p++)
      if (slot(p, TAG_W, stride, ofs, FIELD_W) < 0) begin d[k] = f[p]; k++; end
    return d;
  endfunction

  function automatic logic [BODY_W-1:0] lbl_put(input logic [FIELD_W-1:0] f,
      input logic [LBL_W-1:0] l, input int stride, input int ofs);
    logic [BODY_W-1:0] b;
    int k, s;
    b = '0; k = 0;
    for (int p = 0; p < BODY_W; p++) begin
      s = slot(p, LBL_W, stride, ofs, BODY_W);
      if (s >= 0) b[p] = l[s];
      else begin b[p] = f[k]; k++; end
    end
    return b;
  endfunction

  function automatic logic [LBL_W-1:0] lbl_get(input logic [BODY_W-1:0] b,
      input int stride, input int ofs);
    logic [LBL_W-1:0] l;
    int s;
    l = '0;
    for (int p = 0; p < BODY_W; p++) begin
      s = slot(p, LBL_W, stride, ofs, BODY_W);
      if (s >= 0) l[s] = b[p];
    end
    return l;
  endfunction

  function automatic logic [FIELD_W-1:0] fld_get(input logic [BODY_W-1:0] b,
      input int stride, input int ofs);
    logic [FIELD_W-1:0] f;
    int k;
    f = '0; k = 0;
    for (int p = 0; p < BODY_W; p++)
      if (slot(p, LBL_W, stride, ofs, BODY_W) < 0) begin f[k] = b[p]; k++; end
    return f;
  endfunction
endpackage

// File: rtl/tg_keygen.sv
module tg_keygen
  import tg_pkg::*;
#(
  parameter logic [63:0] LUT = 64'h9E3B_51C7_D2A8_604F
) (
  input  logic [LBL_W-1:0] lbl,
  output logic [TAG_W-1:0] kt,
  output logic [KS_W-1:0]  ks
);
  localparam int NSUB = KEY_W / WORD_W;

  logic [WORD_W-1:0] sel [NSUB];
  logic [WORD_W-1:0] shuf [4];
  logic [KEY_W-1:0]  key;
  logic [1:0]        perm;

  assign perm = lbl[6:5];

  for (genvar s = 0; s < NSUB; s++) begin : g_sub
    assign sel[s] = lbl[s] ? LUT[(2*s+1)*WORD_W +: WORD_W]
                           : LUT[(2*s)*WORD_W +: WORD_W];
  end

  for (genvar i = 0; i < 4; i++) begin : g_shuf
    assign shuf[i] = sel[2'(i) ^ perm];
  end

  always_comb begin
    if (lbl[7]) key = {sel[4], shuf[3], shuf[2], shuf[1], shuf[0]};
    else        key = {shuf[3], shuf[2], shuf[1], shuf[0], sel[4]};
  end

  assign kt = key[KEY_W-1 -: TAG_W];
  assign ks = key[KS_W-1:0];
endmodule

// File: rtl/tg_scramble.sv
module tg_scramble
  import tg_pkg::*;
#(
  parameter bit INVERSE = 1'b0,
  parameter int BLK_W   = 8,
  parameter int NGRP    = 7
) (
  input  logic [FIELD_W-1:0] fin,
  input  logic [KS_W-1:0]    ks,
  output logic [FIELD_W-1:0] fout
);
  localparam int NBLK = (FIELD_W + BLK_W - 1) / BLK_W;
  localparam int BPG  = (NBLK + NGRP - 1) / NGRP;
  localparam int TAIL = FIELD_W - (NBLK - 1) * BLK_W;

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    localparam int W  = (b == NBLK - 1) ? TAIL : BLK_W;
    localparam int LO = b * BLK_W;
    localparam int G  = b / BPG;
    logic [2:0]   ctrl;
    logic [W-1:0] seg;
    int           r;
    assign ctrl = {ks[(G+2)%KS_W], ks[(G+1)%KS_W], ks[G%KS_W]};
    always_comb begin
      r = int'(ctrl) % W;
      for (int i = 0; i < W; i++) begin
        if (INVERSE) seg[i] = fin[LO + (i + r) % W];
        else         seg[(i + r) % W] = fin[LO + i];
      end
    end
    assign fout[LO +: W] = seg;
  end
endmodule

// File: rtl/tg_sender.sv
module tg_sender
  import tg_pkg::*;
#(
  parameter logic [15:0] SEED       = 16'hACE1,
  parameter logic [63:0] LUT        = 64'h9E3B_51C7_D2A8_604F,
  parameter int          TAG_STRIDE = 9,
  parameter int          TAG_OFS    = 2,
  parameter int          LBL_STRIDE = 14,
  parameter int          LBL_OFS    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  logic [DATA_W-1:0] data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PKT_W-1:0]  pkt
);
  logic [15:0]        lfsr;
  logic [LBL_W-1:0]   lbl;
  logic [TAG_W-1:0]   kt;
  logic [KS_W-1:0]    ks;
  logic [FIELD_W-1:0] field, field_s;
  logic               fire;

  assign lbl      = lfsr[LBL_W-1:0];
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  tg_keygen #(.LUT(LUT)) u_key (.lbl(lbl), .kt(kt), .ks(ks));

  assign field = tag_put(data, {src, dst} ^ kt, TAG_STRIDE, TAG_OFS);

  tg_scramble #(.INVERSE(1'b0)) u_scr (.fin(field), .ks(ks), .fout(field_s));

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr      <= SEED;
      out_valid <= 1'b0;
      pkt       <= '0;
    end else begin
      if (fire) begin
        lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        pkt       <= {src, dst, lbl_put(field_s, lbl, LBL_STRIDE, LBL_OFS)};
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tg_receiver.sv
module tg_receiver
  import tg_pkg::*;
#(
  parameter logic [63:0] LUT        = 64'h9E3B_51C7_D2A8_604F,
  parameter int          TAG_STRIDE = 9,
  parameter int          TAG_OFS    = 2,
  parameter int          LBL_STRIDE = 14,
  parameter int          LBL_OFS    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PKT_W-1:0]  pkt,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] dst,
  output logic [DATA_W-1:0] data,
  output logic              alarm
);
  logic [ADDR_W-1:0]  a_src, a_dst;
  logic [BODY_W-1:0]  body;
  logic [LBL_W-1:0]   lbl;
  logic [TAG_W-1:0]   kt, tag_rx;
  logic [KS_W-1:0]    ks;
  logic [FIELD_W-1:0] field_s, field;
  logic               fire, tag_ok;

  assign {a_src, a_dst, body} = pkt;
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;
  assign lbl      = lbl_get(body, LBL_STRIDE, LBL_OFS);
  assign field_s  = fld_get(body, LBL_STRIDE, LBL_OFS);

  tg_keygen #(.LUT(LUT)) u_key (.lbl(lbl), .kt(kt), .ks(ks));
  tg_scramble #(.INVERSE(1'b1)) u_unscr (.fin(field_s), .ks(ks), .fout(field));

  assign tag_rx = tag_get(field, TAG_STRIDE, TAG_OFS);
  assign tag_ok = (tag_rx == ({a_src, a_dst} ^ kt));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      alarm     <= 1'b0;
      src       <= '0;
      dst       <= '0;
      data      <= '0;
    end else begin
      alarm <= fire && !tag_ok;
      if (fire && tag_ok) begin
        out_valid <= 1'b1;
        src       <= a_src;
        dst       <= a_dst;
        data      <= data_get(field, TAG_STRIDE, TAG_OFS);
      end else if (fire || out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pkt_tag_guard.sv
module pkt_tag_guard
  import tg_pkg::*;
#(
  parameter logic [15:0] SEED       = 16'hACE1,
  parameter logic [63:0] LUT        = 64'h9E3B_51C7_D2A8_604F,
  parameter int          TAG_STRIDE = 9,
  parameter int          TAG_OFS    = 2,
  parameter int          LBL_STRIDE = 14,
  parameter int          LBL_OFS    = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tx_valid_i,
  output logic         tx_ready_o,
  input  logic [5:0]   tx_src_i,
  input  logic [5:0]   tx_dst_i,
  input  logic [95:0]  tx_data_i,
  output logic         pkt_valid_o,
  input  logic         pkt_ready_i,
  output logic [127:0] pkt_o,
  input  logic         rx_valid_i,
  output logic         rx_ready_o,
  input  logic [127:0] rx_pkt_i,
  output logic         rx_out_valid_o,
  input  logic         rx_out_ready_i,
  output logic [5:0]   rx_out_src_o,
  output logic [5:0]   rx_out_dst_o,
  output logic [95:0]  rx_out_data_o,
  output logic         hijack_o
);
  tg_sender #(
    .SEED(SEED), .LUT(LUT), .TAG_STRIDE(TAG_STRIDE), .TAG_OFS(TAG_OFS),
    .LBL_STRIDE(LBL_STRIDE), .LBL_OFS(LBL_OFS)
  ) u_tx (
    .clk(clk), .rst(rst), .in_valid(tx_valid_i), .in_ready(tx_ready_o),
    .src(tx_src_i), .dst(tx_dst_i), .data(tx_data_i),
    .out_valid(pkt_valid_o), .out_ready(pkt_ready_i), .pkt(pkt_o)
  );

  tg_receiver #(
    .LUT(LUT), .TAG_STRIDE(TAG_STRIDE), .TAG_OFS(TAG_OFS),
    .LBL_STRIDE(LBL_STRIDE), .LBL_OFS(LBL_OFS)
  ) u_rx (
    .clk(clk), .rst(rst), .in_valid(rx_valid_i), .in_ready(rx_ready_o),
    .pkt(rx_pkt_i), .out_valid(rx_out_valid_o), .out_ready(rx_out_ready_i),
    .src(rx_out_src_o), .dst(rx_out_dst_o), .data(rx_out_data_o),
    .alarm(hijack_o)
  );
endmodule

// File: rtl/tg_guard_chk.sv
module tg_guard_chk (
  input logic         clk,
  input logic         rst,
  input logic         tx_valid_i,
  input logic         tx_ready_o,
  input logic [5:0]   tx_src_i,
  input logic [5:0]   tx_dst_i,
  input logic         pkt_valid_o,
  input logic         pkt_ready_i,
  input logic [127:0] pkt_o,
  input logic         rx_valid_i,
  input logic         rx_ready_o,
  input logic [127:0] rx_pkt_i,
  input logic         rx_out_valid_o,
  input logic [5:0]   rx_out_src_o,
  input logic [5:0]   rx_out_dst_o,
  input logic         hijack_o
);
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pkt_valid_o && !rx_out_valid_o && !hijack_o));

  p_header_kept_r2: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_i && tx_ready_o) |=> (pkt_valid_o && pkt_o[127:122] == $past(tx_src_i)
                                    && pkt_o[121:116] == $past(tx_dst_i)));

  p_deliver_addr_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_valid_i && rx_ready_o) |=> (!rx_out_valid_o ||
      (rx_out_src_o == $past(rx_pkt_i[127:122]) && rx_out_dst_o == $past(rx_pkt_i[121:116]))));

  p_one_outcome_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid_i && rx_ready_o) |=> (rx_out_valid_o != hijack_o));

  p_alarm_cause_r7: assert property (@(posedge clk) disable iff (rst)
    hijack_o |-> $past(rx_valid_i && rx_ready_o));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid_o && !pkt_ready_i) |=> (pkt_valid_o && $stable(pkt_o)));

  p_no_take_r8: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid_o && !pkt_ready_i) |-> !tx_ready_o);
endmodule

bind pkt_tag_guard tg_guard_chk u_chk (.*);

// File: tb/pkt_tag_guard_tb.sv
`timescale 1ns/1ps
module pkt_tag_guard_tb_top;
  localparam logic [15:0] SEED = 16'hACE1;
  localparam logic [63:0] LUT  = 64'h9E3B_51C7_D2A8_604F;

  logic clk = 1'b0, rst = 1'b1;
  logic tx_valid_i = 0, pkt_ready_i = 1, rx_valid_i = 0, rx_out_ready_i = 1;
  logic [5:0] tx_src_i = 0, tx_dst_i = 0;
  logic [95:0] tx_data_i = 0;
  logic [127:0] rx_pkt_i = 0;
  logic tx_ready_o, pkt_valid_o, rx_ready_o, rx_out_valid_o, hijack_o;
  logic [127:0] pkt_o;
  logic [5:0] rx_out_src_o, rx_out_dst_o;
  logic [95:0] rx_out_data_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] m_lfsr;

  always #4 clk = ~clk;

  pkt_tag_guard dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] m_key(input logic [7:0] l);
    logic [3:0] x [5];
    logic [3:0] y [4];
    logic [15:0] a;
    for (int s = 0; s < 5; s++) x[s] = LUT[(2*s + int'(l[s]))*4 +: 4];
    for (int i = 0; i < 4; i++) y[i] = x[i ^ int'(l[6:5])];
    a = {y[3], y[2], y[1], y[0]};
    return l[7] ? {x[4], a} : {a, x[4]};
  endfunction

  function automatic logic [127:0] m_pkt(input logic [5:0] s, input logic [5:0] d,
                                         input logic [95:0] dat, input logic [7:0] l);
    logic [19:0] key; logic [11:0] tag; logic [107:0] f, fs; logic [115:0] b;
    int k, w, g, r, hit;
    key = m_key(l);
    tag = {s, d} ^ key[19:8];
    k = 0;
    for (int p = 0; p < 108; p++) begin
      hit = -1;
      for (int j = 0; j < 12; j++) if ((j*9 + 2) % 108 == p) hit = j;
      if (hit >= 0) f[p] = tag[hit]; else begin f[p] = dat[k]; k++; end
    end
    for (int bk = 0; bk < 14; bk++) begin
      w = (bk == 13) ? 4 : 8; g = bk / 2;
      r = int'({key[(g+2)%8], key[(g+1)%8], key[g%8]}) % w;
      for (int i = 0; i < w; i++) fs[bk*8 + (i + r) % w] = f[bk*8 + i];
    end
    k = 0;
    for (int p = 0; p < 116; p++) begin
      hit = -1;
      for (int j = 0; j < 8; j++) if ((j*14 + 5) % 116 == p) hit = j;
      if (hit >= 0) b[p] = l[hit]; else begin b[p] = fs[k]; k++; end
    end
    return {s, d, b};
  endfunction

  function automatic logic [7:0] lbl_of(input logic [127:0] p);
    logic [7:0] l;
    for (int j = 0; j < 8; j++) l[j] = p[(j*14 + 5) % 116];
    return l;
  endfunction

  // sends one packet through the sender, returns it; pkt_ready_i assumed 1
  task automatic send(input logic [5:0] s, input logic [5:0] d,
                      input logic [95:0] dat, output logic [127:0] got);
    tx_src_i = s; tx_dst_i = d; tx_data_i = dat; tx_valid_i = 1;
    @(posedge clk); @(negedge clk);
    tx_valid_i = 0;
    chk(pkt_valid_o === 1'b1, "R2 valid", {127'd0, pkt_valid_o}, 128'd1);
    got = pkt_o;
    m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
  endtask

  task automatic recv(input logic [127:0] p);
    rx_pkt_i = p; rx_valid_i = 1;
    @(posedge clk); @(negedge clk);
    rx_valid_i = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] p, e, bad;
    logic [95:0] dat;
    logic [5:0] s, d;
    m_lfsr = SEED;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!pkt_valid_o && !rx_out_valid_o && !hijack_o, "R1 outputs idle",
        {125'd0, pkt_valid_o, rx_out_valid_o, hijack_o}, 128'd0);
    chk(tx_ready_o && rx_ready_o, "R1 ready", {126'd0, tx_ready_o, rx_ready_o}, 128'd3);

    // sweep: header, label sequence, full encoding, round trip
    for (int n = 0; n < 300; n++) begin
      s = 6'(n); d = 6'(n * 7 + 3);
      dat = {32'(n * 32'h9E3779B9), 32'(n) ^ 32'h5A5A_0000, ~32'(n * 32'd40503)};
      e = m_pkt(s, d, dat, m_lfsr[7:0]);
      chk(lbl_of(e) == m_lfsr[7:0], "R3 model label", 128'(lbl_of(e)), 128'(m_lfsr[7:0]));
      send(s, d, dat, p);
      chk(p[127:116] == {s, d}, "R2 header", 128'(p[127:116]), 128'({s, d}));
      chk(lbl_of(p) == lbl_of(e), "R3 label", 128'(lbl_of(p)), 128'(lbl_of(e)));
      chk(p == e, "R4 R5 packet", p, e);
      recv(p);
      chk(rx_out_valid_o && !hijack_o, "R6 delivered", {126'd0, rx_out_valid_o, hijack_o}, 128'd2);
      chk(rx_out_data_o == dat && rx_out_src_o == s && rx_out_dst_o == d, "R6 payload",
          {20'd0, rx_out_src_o, rx_out_dst_o, rx_out_data_o}, {20'd0, s, d, dat});
      @(negedge clk);
    end

    // tamper each address bit
    for (int k = 0; k < 12; k++) begin
      for (int n = 0; n < 4; n++) begin
        dat = {3{32'(k * 131 + n * 17 + 5)}};
        send(6'(k * 5 + n), 6'(63 - k - n), dat, p);
        bad = p; bad[116 + k] = ~bad[116 + k];
        recv(bad);
        chk(hijack_o && !rx_out_valid_o, "R7 alarm", {126'd0, hijack_o, rx_out_valid_o}, 128'd2);
        @(negedge clk);
        chk(!hijack_o, "R7 single pulse", {127'd0, hijack_o}, 128'd0);
      end
    end

    // back-pressure on the sender
    pkt_ready_i = 0;
    dat = 96'h0123_4567_89AB_CDEF_0F1E_2D3C;
    e = m_pkt(6'd9, 6'd40, dat, m_lfsr[7:0]);
    send(6'd9, 6'd40, dat, p);
    tx_src_i = 6'd1; tx_dst_i = 6'd2; tx_valid_i = 1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(pkt_valid_o && pkt_o == e && !tx_ready_o, "R8 hold", pkt_o, e);
    end
    pkt_ready_i = 1;
    @(posedge clk); @(negedge clk);
    tx_valid_i = 0;
    e = m_pkt(6'd1, 6'd2, dat, m_lfsr[7:0]);
    m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    chk(pkt_valid_o && pkt_o == e, "R8 next after release R3", pkt_o, e);
    @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule